// File: doc/BRIEF.md
# Indirect Configuration Register Port

This block holds the setup registers of a two-channel disk interface and reaches them through a narrow window of two host locations. The host writes a byte-wide pointer that names a channel and a register index. It then reads or writes a word-wide data location, which lands in the register that the pointer selects. If the pointer's advance bit is set, the index steps forward after every data access. A whole bank can then be loaded or dumped with one pointer write followed by a run of data accesses.

Each channel has seven registers. These are two 16-bit base addresses, a general control byte, a 10-bit read-ahead count split over two registers, and two timing bytes. Every register has its own reset value. The read-ahead registers are write-only, and one of their bits is a strobe that is never stored. All stored values are driven out as parallel outputs, so the logic that uses them needs no access cycle.

Top module: `idx_cfg_port`

## Requirements
- R1: `acc_addr`=1 selects the pointer and `acc_addr`=0 selects the data register. A read strobe returns its value on `acc_rdata` with `acc_rvalid` high in the cycle after the strobe. At most one of `acc_wr` and `acc_rd` is high in any cycle.
- R2: The pointer resets to 0x50. Its bits are: bit 7 advance enable, bit 6 posted-write wait (`posted_wait_o`), bit 5 burst disable (`burst_dis_o`, write-only, reads as 0), bit 4 medium device-select timing (`devsel_med_o`), bit 3 channel (0 first, 1 second), and bits 2..0 register index. A pointer read returns the byte zero-extended to 16 bits.
- R3: When pointer bit 7 is 1, each read or write of the data register advances the index by one after the access, and index 6 or 7 advances to 0. When bit 7 is 0 the pointer does not change. A pointer write never advances the index.
- R4: Reset values are: index 0 = 0x1F0 (channel 0) or 0x170 (channel 1), index 1 = 0x01, index 4 = 0x3F6 or 0x376, index 5 = 0xF5, index 6 = 0xDE, and a read-ahead count and enable of 0.
- R5: A data write stores into the register of the selected channel and index. Indices 0 and 4 keep all 16 bits. The other indices keep the low byte, which a read returns zero-extended.
- R6: Index 1 drives these outputs: bit 7 `dma_en_o`, bit 6 `ide_rst_o`, bit 5 `iordy_en_o`, bit 4 `byte_mode_o`, bit 3 `irq_low_o`, bit 0 `io_en_o`.
- R7: `ra_count_o` is {index 3 bits 1..0, index 2 bits 7..0}, and `ra_en_o` is index 3 bit 7. Reads of index 2 and index 3 return 0.
- R8: A write to index 3 with bit 6 set drives that channel's `fifo_clr_o` high for exactly the one cycle after the write. The bit is not stored.
- R9: A data write at index 7 changes no register, and a data read at index 7 returns 0.
- R10: The two channels hold separate values. A write to one channel leaves the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 1 | 0 data register, 1 pointer |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, registered |
| acc_rvalid | output | 1 | Read data valid |
| posted_wait_o | output | 1 | Pointer bit 6 |
| burst_dis_o | output | 1 | Pointer bit 5 |
| devsel_med_o | output | 1 | Pointer bit 4 |
| cmd_base_o | output | 2x16 | Index 0 per channel |
| ctl_base_o | output | 2x16 | Index 4 per channel |
| dma_en_o | output | 2 | Index 1 bit 7 per channel |
| ide_rst_o | output | 2 | Index 1 bit 6 per channel |
| iordy_en_o | output | 2 | Index 1 bit 5 per channel |
| byte_mode_o | output | 2 | Index 1 bit 4 per channel |
| irq_low_o | output | 2 | Index 1 bit 3 per channel |
| io_en_o | output | 2 | Index 1 bit 0 per channel |
| ra_count_o | output | 2x10 | Read-ahead count per channel |
| ra_en_o | output | 2 | Read-ahead enable per channel |
| fifo_clr_o | output | 2 | FIFO-clear pulse per channel |
| data_tim_o | output | 2x8 | Index 5 per channel |
| cmd_tim_o | output | 2x8 | Index 6 per channel |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. Without that rule, a single data access could not be told apart from two, and the advance check would be ambiguous. The bench drives exactly one strobe per access, raises it on a falling edge, and drops it on the next falling edge. It reads the index 7 and write-only cases back through the data window, and it observes the strobe pulse directly on the output pins.

// File: rtl/icrp_pkg.sv
package icrp_pkg;
  localparam int DW   = 16;
  localparam int BW   = 8;
  localparam int IW   = 3;
  localparam int NCH  = 2;
  localparam int NREG = 7;
  localparam int RAW  = 10;

  localparam logic [IW-1:0] IX_CMD  = 3'd0;
  localparam logic [IW-1:0] IX_GEN  = 3'd1;
  localparam logic [IW-1:0] IX_RALO = 3'd2;
  localparam logic [IW-1:0] IX_RACF = 3'd3;
  localparam logic [IW-1:0] IX_CTL  = 3'd4;
  localparam logic [IW-1:0] IX_DTIM = 3'd5;
  localparam logic [IW-1:0] IX_CTIM = 3'd6;

  localparam logic [BW-1:0] PTR_RST = 8'h50;
  localparam logic [BW-1:0] GEN_RST = 8'h01;
  localparam logic [BW-1:0] DTIM_RST = 8'hF5;
  localparam logic [BW-1:0] CTIM_RST = 8'hDE;

  function automatic logic [DW-1:0] cmd_base_rst(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [DW-1:0] ctl_base_rst(input int ch);
    return (ch == 0) ? 16'h03F6 : 16'h0376;
  endfunction
endpackage

// File: rtl/icrp_pointer.sv
module icrp_pointer
  import icrp_pkg::*;
#(
  parameter int LAST = NREG - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_wr,
  input  logic [BW-1:0] ptr_wdata,
  input  logic          data_acc,
  output logic [BW-1:0] ptr_q
);
  logic [IW-1:0] idx_nxt;

  always_comb begin
    if (ptr_q[IW-1:0] >= IW'(LAST)) idx_nxt = '0;
    else                            idx_nxt = ptr_q[IW-1:0] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= PTR_RST;
    else if (ptr_wr) ptr_q <= ptr_wdata;
    else if (data_acc && ptr_q[7]) ptr_q[IW-1:0] <= idx_nxt;
  end

  // R3: an advancing access moves the index up by one or wraps it to 0
  assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !ptr_wr && ptr_q[7]) |=>
      ((ptr_q[IW-1:0] == '0) || (ptr_q[IW-1:0] == $past(ptr_q[IW-1:0]) + 1'b1))
      && $stable(ptr_q[BW-1:IW]));

  // R3: without the advance bit a data access leaves the pointer alone
  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !ptr_wr && !ptr_q[7]) |=> $stable(ptr_q));
endmodule

// File: rtl/icrp_bank.sv
module icrp_bank
  import icrp_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [DW-1:0]  wdata,
  input  logic [IW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_val,
  output logic [DW-1:0]  cmd_base,
  output logic [DW-1:0]  ctl_base,
  output logic [BW-1:0]  gen_cfg,
  output logic [RAW-1:0] ra_count,
  output logic           ra_en,
  output logic           fifo_clr,
  output logic [BW-1:0]  data_tim,
  output logic [BW-1:0]  cmd_tim
);
  localparam logic [DW-1:0] CMD_RST = cmd_base_rst(CH);
  localparam logic [DW-1:0] CTL_RST = ctl_base_rst(CH);

  logic [BW-1:0]     ra_lo;
  logic [RAW-BW-1:0] ra_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_base <= CMD_RST;
      ctl_base <= CTL_RST;
      gen_cfg  <= GEN_RST;
      ra_lo    <= '0;
      ra_hi    <= '0;
      ra_en    <= 1'b0;
      fifo_clr <= 1'b0;
      data_tim <= DTIM_RST;
      cmd_tim  <= CTIM_RST;
    end else begin
      fifo_clr <= 1'b0;
      if (wr_en) begin
        case (wr_idx)
          IX_CMD:  cmd_base <= wdata;
          IX_GEN:  gen_cfg  <= wdata[BW-1:0];
          IX_RALO: ra_lo    <= wdata[BW-1:0];
          IX_RACF: begin
            ra_en    <= wdata[7];
            fifo_clr <= wdata[6];
            ra_hi    <= wdata[RAW-BW-1:0];
          end
          IX_CTL:  ctl_base <= wdata;
          IX_DTIM: data_tim <= wdata[BW-1:0];
          IX_CTIM: cmd_tim  <= wdata[BW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign ra_count = {ra_hi, ra_lo};

  always_comb begin
    case (rd_idx)
      IX_CMD:  rd_val = cmd_base;
      IX_GEN:  rd_val = {{(DW-BW){1'b0}}, gen_cfg};
      IX_CTL:  rd_val = ctl_base;
      IX_DTIM: rd_val = {{(DW-BW){1'b0}}, data_tim};
      IX_CTIM: rd_val = {{(DW-BW){1'b0}}, cmd_tim};
      default: rd_val = '0;
    endcase
  end

  // R9: a write at index 7 leaves every register as it was
  assert_idx7_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == 3'd7) |=>
      $stable(cmd_base) && $stable(ctl_base) && $stable(gen_cfg) && $stable(ra_count)
      && $stable(ra_en) && $stable(data_tim) && $stable(cmd_tim));

  // R8: the clear pulse only follows a write of index 3 with bit 6 set
  assert_fifo_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |-> $past(wr_en && wr_idx == IX_RACF && wdata[6]));
endmodule

// File: rtl/idx_cfg_port.sv
module idx_cfg_port
  import icrp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_addr,
  input  logic                     acc_wr,
  input  logic                     acc_rd,
  input  logic [15:0]              acc_wdata,
  output logic [15:0]              acc_rdata,
  output logic                     acc_rvalid,
  output logic                     posted_wait_o,
  output logic                     burst_dis_o,
  output logic                     devsel_med_o,
  output logic [1:0][15:0]         cmd_base_o,
  output logic [1:0][15:0]         ctl_base_o,
  output logic [1:0]               dma_en_o,
  output logic [1:0]               ide_rst_o,
  output logic [1:0]               iordy_en_o,
  output logic [1:0]               byte_mode_o,
  output logic [1:0]               irq_low_o,
  output logic [1:0]               io_en_o,
  output logic [1:0][9:0]          ra_count_o,
  output logic [1:0]               ra_en_o,
  output logic [1:0]               fifo_clr_o,
  output logic [1:0][7:0]          data_tim_o,
  output logic [1:0][7:0]          cmd_tim_o
);
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_PTR  = 1'b1;
  localparam logic [BW-1:0] PTR_RD_MASK = 8'hDF;

  logic [BW-1:0] ptr_q;
  logic          ptr_wr, data_acc, data_wr;
  logic          ch_sel;
  logic [NCH-1:0][DW-1:0] bank_rd;
  logic [NCH-1:0][BW-1:0] gen_cfg;

  assign ptr_wr   = acc_wr && (acc_addr == ADDR_PTR);
  assign data_acc = (acc_wr || acc_rd) && (acc_addr == ADDR_DATA);
  assign data_wr  = acc_wr && (acc_addr == ADDR_DATA);
  assign ch_sel   = ptr_q[IW];

  icrp_pointer u_ptr (
    .clk      (clk),
    .rst      (rst),
    .ptr_wr   (ptr_wr),
    .ptr_wdata(acc_wdata[BW-1:0]),
    .data_acc (data_acc),
    .ptr_q    (ptr_q)
  );

  assign posted_wait_o = ptr_q[6];
  assign burst_dis_o   = ptr_q[5];
  assign devsel_med_o  = ptr_q[4];

  for (genvar c = 0; c < NCH; c++) begin : g_bank
    icrp_bank #(.CH(c)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (data_wr && (ch_sel == c[0])),
      .wr_idx  (ptr_q[IW-1:0]),
      .wdata   (acc_wdata),
      .rd_idx  (ptr_q[IW-1:0]),
      .rd_val  (bank_rd[c]),
      .cmd_base(cmd_base_o[c]),
      .ctl_base(ctl_base_o[c]),
      .gen_cfg (gen_cfg[c]),
      .ra_count(ra_count_o[c]),
      .ra_en   (ra_en_o[c]),
      .fifo_clr(fifo_clr_o[c]),
      .data_tim(data_tim_o[c]),
      .cmd_tim (cmd_tim_o[c])
    );
    assign dma_en_o[c]    = gen_cfg[c][7];
    assign ide_rst_o[c]   = gen_cfg[c][6];
    assign iordy_en_o[c]  = gen_cfg[c][5];
    assign byte_mode_o[c] = gen_cfg[c][4];
    assign irq_low_o[c]   = gen_cfg[c][3];
    assign io_en_o[c]     = gen_cfg[c][0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata  <= '0;
      acc_rvalid <= 1'b0;
    end else begin
      acc_rvalid <= acc_rd;
      if (acc_rd) begin
        if (acc_addr == ADDR_PTR) acc_rdata <= {{(DW-BW){1'b0}}, ptr_q & PTR_RD_MASK};
        else                      acc_rdata <= bank_rd[ch_sel];
      end
    end
  end

  // R1: the host raises one strobe at a time
  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !(acc_wr && acc_rd));

  // R1: read data is valid exactly one cycle after a read strobe
  assert_rvalid_timing_R1: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> acc_rvalid);

  // R7: write-only registers read back as zero
  assert_wo_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_addr == ADDR_DATA &&
     (ptr_q[IW-1:0] == IX_RALO || ptr_q[IW-1:0] == IX_RACF)) |=> (acc_rdata == '0));

  // R2: the burst-disable bit never shows in a pointer read
  assert_ptr_bit5_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && acc_addr == ADDR_PTR) |=> (acc_rdata[5] == 1'b0));
endmodule

// File: tb/idx_cfg_port_tb.sv
module idx_cfg_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_addr = 1'b0, acc_wr = 1'b0, acc_rd = 1'b0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] acc_rdata;
  logic acc_rvalid, posted_wait_o, burst_dis_o, devsel_med_o;
  logic [1:0][15:0] cmd_base_o, ctl_base_o;
  logic [1:0] dma_en_o, ide_rst_o, iordy_en_o, byte_mode_o, irq_low_o, io_en_o;
  logic [1:0][9:0] ra_count_o;
  logic [1:0] ra_en_o, fifo_clr_o;
  logic [1:0][7:0] data_tim_o, cmd_tim_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  idx_cfg_port u_dut (.*);

  // row: {is_read, addr, data, expected, req}
  localparam int NV = 34;
  localparam logic [37:0] VEC [NV] = '{
    {1'b1,1'b1,16'h0000,16'h0050,4'd2},  // R2 pointer reset
    {1'b1,1'b0,16'h0000,16'h01F0,4'd4},  // R4 idx0 ch0, no advance
    {1'b0,1'b1,16'h0080,16'h0000,4'd3},
    {1'b1,1'b1,16'h0000,16'h0080,4'd3},  // R3 still idx0 after plain read
    {1'b1,1'b0,16'h0000,16'h01F0,4'd3},
    {1'b1,1'b0,16'h0000,16'h0001,4'd4},
    {1'b1,1'b0,16'h0000,16'h0000,4'd7},  // R7 idx2 reads 0
    {1'b1,1'b0,16'h0000,16'h0000,4'd7},  // R7 idx3 reads 0
    {1'b1,1'b0,16'h0000,16'h03F6,4'd4},
    {1'b1,1'b0,16'h0000,16'h00F5,4'd4},
    {1'b1,1'b0,16'h0000,16'h00DE,4'd4},
    {1'b1,1'b0,16'h0000,16'h01F0,4'd3},  // R3 wrap 6 -> 0
    {1'b0,1'b1,16'h0088,16'h0000,4'd3},
    {1'b1,1'b0,16'h0000,16'h0170,4'd4},
    {1'b1,1'b1,16'h0000,16'h0089,4'd3},
    {1'b0,1'b1,16'h008C,16'h0000,4'd3},
    {1'b1,1'b0,16'h0000,16'h0376,4'd4},
    {1'b1,1'b0,16'h0000,16'h00F5,4'd4},
    {1'b0,1'b1,16'h0027,16'h0000,4'd2},
    {1'b1,1'b1,16'h0000,16'h0007,4'd2},  // R2 bit5 reads 0
    {1'b0,1'b0,16'hFFFF,16'h0000,4'd9},
    {1'b1,1'b0,16'h0000,16'h0000,4'd9},  // R9 idx7 reads 0
    {1'b1,1'b1,16'h0000,16'h0007,4'd3},  // R3 no advance without bit7
    {1'b0,1'b1,16'h0080,16'h0000,4'd9},
    {1'b1,1'b0,16'h0000,16'h01F0,4'd9},  // R9 nothing written
    {1'b1,1'b0,16'h0000,16'h0001,4'd9},
    {1'b0,1'b1,16'h0000,16'h0000,4'd5},
    {1'b0,1'b0,16'h1234,16'h0000,4'd5},
    {1'b1,1'b0,16'h0000,16'h1234,4'd5},  // R5 full word
    {1'b0,1'b1,16'h0008,16'h0000,4'd10},
    {1'b1,1'b0,16'h0000,16'h0170,4'd10}, // R10 other channel intact
    {1'b0,1'b1,16'h0005,16'h0000,4'd5},
    {1'b0,1'b0,16'hAB12,16'h0000,4'd5},
    {1'b1,1'b0,16'h0000,16'h0012,4'd5}   // R5 byte register
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic do_rd(input logic a, input string req, input logic [15:0] exp);
    @(negedge clk);
    acc_addr = a; acc_rd = 1'b1;
    @(negedge clk);
    acc_rd = 1'b0;
    check({req, " rvalid"}, {31'd0, acc_rvalid}, 32'd1);
    check(req, {16'd0, acc_rdata}, {16'd0, exp});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R4 reset state at the outputs
    check("R4 cmd0", {16'd0, cmd_base_o[0]}, 32'h01F0);
    check("R4 cmd1", {16'd0, cmd_base_o[1]}, 32'h0170);
    check("R4 ctl0", {16'd0, ctl_base_o[0]}, 32'h03F6);
    check("R4 ctl1", {16'd0, ctl_base_o[1]}, 32'h0376);
    check("R4 tim", {16'd0, data_tim_o[1], cmd_tim_o[0]}, 32'hF5DE);
    check("R4 gen", {26'd0, io_en_o, dma_en_o, ra_en_o}, 32'h30);
    check("R4 ra", {12'd0, ra_count_o}, 32'd0);
    check("R2 ptr fields", {29'd0, posted_wait_o, burst_dis_o, devsel_med_o}, 32'h5);
    check("R1 rvalid idle", {31'd0, acc_rvalid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) do_rd(VEC[i][36], $sformatf("R%0d row%0d", VEC[i][3:0], i), VEC[i][19:4]);
      else            do_wr(VEC[i][36], VEC[i][35:20]);
    end

    // R6 general control fields
    do_wr(1'b1, 16'h0001);
    do_wr(1'b0, 16'h00F9);
    check("R6 fields ch0",
          {26'd0, dma_en_o[0], ide_rst_o[0], iordy_en_o[0], byte_mode_o[0], irq_low_o[0], io_en_o[0]},
          32'h3F);
    check("R6 R10 ch1 untouched", {30'd0, dma_en_o[1], io_en_o[1]}, 32'h1);
    do_wr(1'b0, 16'h0000);
    check("R6 io_en off", {30'd0, io_en_o[0], dma_en_o[0]}, 32'h0);

    // R7 read-ahead count across two registers
    do_wr(1'b1, 16'h000A);
    do_wr(1'b0, 16'h005A);
    do_wr(1'b1, 16'h000B);
    do_wr(1'b0, 16'h0083);
    check("R7 count", {22'd0, ra_count_o[1]}, 32'h35A);
    check("R7 enable", {30'd0, ra_en_o}, 32'h2);
    check("R8 no pulse", {30'd0, fifo_clr_o}, 32'h0);
    do_rd(1'b0, "R7 idx3 reads 0", 16'h0000);

    // R8 clear strobe lasts one cycle and is not stored
    do_wr(1'b0, 16'h00C1);
    check("R8 pulse high", {30'd0, fifo_clr_o}, 32'h2);
    @(negedge clk);
    check("R8 pulse gone", {30'd0, fifo_clr_o}, 32'h0);
    check("R8 R7 count after", {22'd0, ra_count_o[1]}, 32'h15A);
    do_rd(1'b0, "R8 not stored", 16'h0000);

    // R2 pointer output fields and write-only bit
    do_wr(1'b1, 16'h0070);
    check("R2 fields set", {29'd0, posted_wait_o, burst_dis_o, devsel_med_o}, 32'h7);
    do_rd(1'b1, "R2 ptr read", 16'h0050);

    finish_run();
  end
endmodule